// File: doc/BRIEF.md
# Operating-System Match Timer

This block is a general-purpose system timer for an operating system's scheduler and watchdog. A single 32-bit up-counter advances by one on every cycle in which the `tick_en` input is high. That input is the enable derived from a fixed reference rate, typically a few megahertz. Four 32-bit compare registers are each checked against the counter whenever it advances. When the counter reaches a compare value, the matching channel latches a pending flag and raises its interrupt line. This happens only if that channel's enable bit is set.

Software reaches the block through a simple single-cycle register port. Writes take effect at the clock edge. Read data and the address-error flag are combinational from the request in the same cycle. Pending flags are cleared by writing ones to the status word. Channel 3 can also act as a watchdog. Once a sticky arm bit has been set, a compare hit on channel 3 produces a one-cycle reset request.

Register word offsets:

| Offset | Register |
|---|---|
| 0x00, 0x04, 0x08, 0x0C | Compare channels 0 to 3 |
| 0x10 | Counter |
| 0x14 | Pending flags; bit n belongs to channel n |
| 0x18 | Watchdog arm; bit 0 |
| 0x1C | Interrupt enable; bit n enables channel n |

Top module: `os_match_timer`

## Requirements
- R1: After synchronous reset the counter, all compare registers, the pending flags, the enable word and the watchdog arm bit read 0, and `irq` and `wdt_reset_req` are low.
- R2: The counter increases by exactly 1 on each clock edge where `tick_en` is high and holds otherwise. It wraps from 0xFFFFFFFF to 0.
- R3: A write to offset 0x10 loads the counter with the written data. The load has priority over a tick in the same cycle, and counting resumes from the loaded value.
- R4: The counter may advance onto the value held in compare register n while bit n of the enable word is 1. In that case bit n of the pending word (offset 0x14) is set, and `irq[n]` is high from the edge that advanced the counter on.
- R5: A compare hit on a channel whose enable bit is 0 leaves that channel's pending bit and `irq` line at 0.
- R6: The enable word at 0x1C stores only the low 12 bits of written data. Its upper 20 bits read as 0. Bits 3:0 gate channels 0 to 3.
- R7: Writing the pending word clears each pending bit written as 1 and leaves bits written as 0 unchanged. A hit that occurs in the same cycle as a clear of that bit wins, so the bit stays set.
- R8: Writing 1 to bit 0 of offset 0x18 arms the watchdog. Writing 0 does not disarm it; only reset does. While armed, a channel 3 hit drives `wdt_reset_req` high for exactly one cycle, whatever the state of enable bit 3.
- R9: An access to any offset other than the eight listed words asserts `addr_err` in the same cycle, and a read there returns 0.
- R10: Compare registers 0 to 3 at offsets 0x00, 0x04, 0x08 and 0x0C are written and read back as full 32-bit values.
- R11: Compares are evaluated only on a tick. Loading the counter with a value equal to a compare register does not set a pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Reference-rate count enable |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid in the request cycle |
| addr_err | output | 1 | Access to an unmapped offset |
| irq | output | 4 | Per-channel interrupt levels |
| wdt_reset_req | output | 1 | One-cycle system reset request |

## Verification
The bench targets the wrap from all ones to zero with a compare set at 0. A design that compares before incrementing, or that misses the carry, would never flag that channel. It also drives a tick and a clear of the same pending bit in one cycle. A design that lets the clear win would lose the interrupt. The counter is loaded directly onto a compare value to catch designs that compare on every cycle rather than on ticks. The bench writes 0 to the watchdog arm bit to catch a non-sticky arm, and it checks that the reset request falls after one cycle.

// File: rtl/os_tmr_pkg.sv
package os_tmr_pkg;

    localparam int NUM_CH   = 4;
    localparam int WORD_W   = 32;
    localparam int MASK_W   = 12;
    localparam int OFF_W    = 8;
    localparam int WDT_CH   = 3;

    localparam logic [OFF_W-1:0] OFF_CMP0   = 8'h00;
    localparam logic [OFF_W-1:0] OFF_COUNT  = 8'h10;
    localparam logic [OFF_W-1:0] OFF_PEND   = 8'h14;
    localparam logic [OFF_W-1:0] OFF_ARM    = 8'h18;
    localparam logic [OFF_W-1:0] OFF_ENABLE = 8'h1C;

    typedef enum logic [2:0] {
        SEL_CMP,
        SEL_COUNT,
        SEL_PEND,
        SEL_ARM,
        SEL_ENABLE,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e   sel;
        logic [1:0] chan;
    } decode_t;

    function automatic decode_t decode_offset(input logic [OFF_W-1:0] off);
        decode_t d;
        d.chan = off[3:2];
        if (off[1:0] != 2'b00) begin
            d.sel = SEL_NONE;
        end else if (off < OFF_COUNT) begin
            d.sel = SEL_CMP;
        end else begin
            case (off)
                OFF_COUNT:  d.sel = SEL_COUNT;
                OFF_PEND:   d.sel = SEL_PEND;
                OFF_ARM:    d.sel = SEL_ARM;
                OFF_ENABLE: d.sel = SEL_ENABLE;
                default:    d.sel = SEL_NONE;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/os_tmr_decode.sv
module os_tmr_decode
    import os_tmr_pkg::*;
(
    input  logic             req_valid,
    input  logic [OFF_W-1:0] req_addr,
    output decode_t          dec,
    output logic             bad
);
    always_comb begin
        dec = decode_offset(req_addr);
        bad = req_valid && (dec.sel == SEL_NONE);
    end
endmodule

// File: rtl/os_tmr_counter.sv
module os_tmr_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] value,
    output logic [W-1:0] value_next,
    output logic         advance
);
    always_comb begin
        advance    = tick && !load;
        value_next = value + {{(W-1){1'b0}}, 1'b1};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (load) begin
            value <= load_val;
        end else if (tick) begin
            value <= value_next;
        end
    end
endmodule

// File: rtl/os_tmr_channel.sv
module os_tmr_channel #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cmp_wr,
    input  logic [W-1:0] wdata,
    input  logic         advance,
    input  logic [W-1:0] cnt_next,
    input  logic         enable,
    input  logic         clear,
    output logic [W-1:0] cmp_value,
    output logic         hit,
    output logic         pending
);
    always_comb begin
        hit = advance && (cnt_next == cmp_value);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_value <= '0;
        end else if (cmp_wr) begin
            cmp_value <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
        end else if (hit && enable) begin
            pending <= 1'b1;
        end else if (clear) begin
            pending <= 1'b0;
        end
    end
endmodule

// File: rtl/os_match_timer.sv
module os_match_timer
    import os_tmr_pkg::*;
#(
    parameter int CNT_W = WORD_W,
    parameter int EN_W  = MASK_W,
    localparam int NCH  = NUM_CH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [OFF_W-1:0] req_addr,
    input  logic [CNT_W-1:0] req_wdata,
    output logic [CNT_W-1:0] rsp_rdata,
    output logic             addr_err,
    output logic [NCH-1:0]   irq,
    output logic             wdt_reset_req
);
    decode_t          dec;
    logic             wr_any;
    logic             wr_cnt;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;
    logic             cnt_adv;
    logic [EN_W-1:0]  en_q;
    logic             wdt_en_q;
    logic [NCH-1:0]   hit_v;
    logic [NCH-1:0]   pend_v;
    logic [CNT_W-1:0] cmp_v [NCH];

    os_tmr_decode u_dec (
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .dec       (dec),
        .bad       (addr_err)
    );

    assign wr_any = req_valid && req_write;
    assign wr_cnt = wr_any && (dec.sel == SEL_COUNT);

    os_tmr_counter #(.W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick_en),
        .load       (wr_cnt),
        .load_val   (req_wdata),
        .value      (cnt_q),
        .value_next (cnt_next),
        .advance    (cnt_adv)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        os_tmr_channel #(.W(CNT_W)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .cmp_wr    (wr_any && dec.sel == SEL_CMP && dec.chan == c),
            .wdata     (req_wdata),
            .advance   (cnt_adv),
            .cnt_next  (cnt_next),
            .enable    (en_q[c]),
            .clear     (wr_any && dec.sel == SEL_PEND && req_wdata[c]),
            .cmp_value (cmp_v[c]),
            .hit       (hit_v[c]),
            .pending   (pend_v[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (wr_any && dec.sel == SEL_ENABLE) begin
            en_q <= req_wdata[EN_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wdt_en_q <= 1'b0;
        end else if (wr_any && dec.sel == SEL_ARM && req_wdata[0]) begin
            wdt_en_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wdt_reset_req <= 1'b0;
        end else begin
            wdt_reset_req <= wdt_en_q && hit_v[WDT_CH];
        end
    end

    assign irq = pend_v;

    always_comb begin
        rsp_rdata = '0;
        if (req_valid && !req_write) begin
            case (dec.sel)
                SEL_CMP:    rsp_rdata = cmp_v[dec.chan];
                SEL_COUNT:  rsp_rdata = cnt_q;
                SEL_PEND:   rsp_rdata = {{(CNT_W-NCH){1'b0}}, pend_v};
                SEL_ARM:    rsp_rdata = {{(CNT_W-1){1'b0}}, wdt_en_q};
                SEL_ENABLE: rsp_rdata = {{(CNT_W-EN_W){1'b0}}, en_q};
                default:    rsp_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/os_match_timer_chk.sv
module os_match_timer_chk #(
    parameter int CNT_W = 32,
    parameter int NCH   = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_en,
    input logic             wr_cnt,
    input logic [CNT_W-1:0] cnt_q,
    input logic [NCH-1:0]   irq,
    input logic [NCH-1:0]   en_lo,
    input logic             wdt_en_q,
    input logic             wdt_reset_req,
    input logic             addr_err,
    input logic [CNT_W-1:0] rsp_rdata
);
    AST_RESET_CLEAN: assert property (@(posedge clk)
        rst |=> (irq == '0 && cnt_q == '0 && !wdt_reset_req && !wdt_en_q)); // R1

    AST_TICK_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !wr_cnt) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !wr_cnt) |=> $stable(cnt_q)); // R2

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        ((irq & ~$past(irq) & ~$past(en_lo)) == '0)); // R5

    AST_ARM_STICKY: assert property (@(posedge clk) disable iff (rst)
        wdt_en_q |=> wdt_en_q); // R8

    AST_WDT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        wdt_reset_req |=> !wdt_reset_req); // R8

    AST_WDT_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
        $rose(wdt_reset_req) |-> $past(wdt_en_q)); // R8

    AST_ERR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        addr_err |-> (rsp_rdata == '0)); // R9
endmodule

bind os_match_timer os_match_timer_chk #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .tick_en       (tick_en),
    .wr_cnt        (wr_cnt),
    .cnt_q         (cnt_q),
    .irq           (irq),
    .en_lo         (en_q[NCH-1:0]),
    .wdt_en_q      (wdt_en_q),
    .wdt_reset_req (wdt_reset_req),
    .addr_err      (addr_err),
    .rsp_rdata     (rsp_rdata)
);

// File: tb/os_match_timer_bench.sv
module os_match_timer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        addr_err;
    logic [3:0]  irq;
    logic        wdt_reset_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    os_match_timer u_os_match_timer (
        .clk           (clk),
        .rst           (rst),
        .tick_en       (tick_en),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .rsp_rdata     (rsp_rdata),
        .addr_err      (addr_err),
        .irq           (irq),
        .wdt_reset_req (wdt_reset_req)
    );

    // {write, offset, data, expected read}
    localparam logic [72:0] VEC [10] = '{
        {1'b1, 8'h00, 32'hA5A5_0001, 32'h0},
        {1'b1, 8'h04, 32'h0000_1234, 32'h0},
        {1'b1, 8'h08, 32'hFFFF_FFFF, 32'h0},
        {1'b1, 8'h0C, 32'h8000_0000, 32'h0},
        {1'b0, 8'h00, 32'h0,         32'hA5A5_0001},
        {1'b0, 8'h04, 32'h0,         32'h0000_1234},
        {1'b0, 8'h08, 32'h0,         32'hFFFF_FFFF},
        {1'b0, 8'h0C, 32'h0,         32'h8000_0000},
        {1'b1, 8'h1C, 32'hABCD_E123, 32'h0},
        {1'b0, 8'h1C, 32'h0,         32'h0000_0123}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic e);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        #1;
        d = rsp_rdata;
        e = addr_err;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        logic [31:0] d;
        logic        e;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(8'h10, d, e); check("R1 count", d, 32'h0);
        rd(8'h04, d, e); check("R1 cmp1", d, 32'h0);
        rd(8'h14, d, e); check("R1 pend", d, 32'h0);
        check("R1 irq", {28'h0, irq}, 32'h0);

        // R10 / R6 table walk
        for (int i = 0; i < 10; i++) begin
            if (VEC[i][72]) begin
                wr(VEC[i][71:64], VEC[i][63:32]);
            end else begin
                rd(VEC[i][71:64], d, e);
                check($sformatf("R10/R6 vec%0d", i), d, VEC[i][31:0]);
            end
        end

        // R3 load and R2 count
        wr(8'h10, 32'd100);
        rd(8'h10, d, e); check("R3 load", d, 32'd100);
        ticks(5);
        rd(8'h10, d, e); check("R2 count5", d, 32'd105);
        repeat (3) @(negedge clk);
        rd(8'h10, d, e); check("R2 hold", d, 32'd105);

        // R4 enabled match
        wr(8'h1C, 32'h1);
        wr(8'h00, 32'd110);
        ticks(5);
        check("R4 irq0", {28'h0, irq}, 32'h1);
        rd(8'h14, d, e); check("R4 pend", d, 32'h1);

        // R7 write-one-to-clear
        wr(8'h14, 32'h2);
        rd(8'h14, d, e); check("R7 zero keeps", d, 32'h1);
        wr(8'h14, 32'h1);
        rd(8'h14, d, e); check("R7 one clears", d, 32'h0);

        // R5 disabled channel
        wr(8'h04, 32'd200);
        wr(8'h10, 32'd195);
        ticks(5);
        rd(8'h10, d, e); check("R5 count", d, 32'd200);
        rd(8'h14, d, e); check("R5 pend", d, 32'h0);
        check("R5 irq", {28'h0, irq}, 32'h0);

        // R7 set beats clear in the same cycle
        wr(8'h10, 32'd109);
        tick_en = 1'b1;
        wr(8'h14, 32'hF);
        tick_en = 1'b0;
        rd(8'h14, d, e); check("R7 set wins", d, 32'h1);
        wr(8'h14, 32'hF);

        // R3 load priority over tick
        tick_en = 1'b1;
        wr(8'h10, 32'd500);
        tick_en = 1'b0;
        rd(8'h10, d, e); check("R3 priority", d, 32'd500);

        // R11 load onto a compare value does not hit
        wr(8'h10, 32'd110);
        rd(8'h14, d, e); check("R11 no hit", d, 32'h0);

        // R2 wrap with compare at zero
        wr(8'h08, 32'h0);
        wr(8'h1C, 32'h5);
        wr(8'h10, 32'hFFFF_FFFE);
        ticks(2);
        rd(8'h10, d, e); check("R2 wrap", d, 32'h0);
        rd(8'h14, d, e); check("R4 wrap hit", d, 32'h4);
        wr(8'h14, 32'hF);

        // R8 watchdog
        wr(8'h0C, 32'd300);
        wr(8'h10, 32'd299);
        ticks(1);
        check("R8 unarmed", {31'h0, wdt_reset_req}, 32'h0);
        wr(8'h18, 32'h1);
        wr(8'h18, 32'h0);
        rd(8'h18, d, e); check("R8 sticky", d, 32'h1);
        wr(8'h10, 32'd299);
        ticks(1);
        check("R8 request", {31'h0, wdt_reset_req}, 32'h1);
        @(negedge clk);
        check("R8 one cycle", {31'h0, wdt_reset_req}, 32'h0);
        rd(8'h14, d, e); check("R8 no pend3", d, 32'h0);

        // R9 unmapped offsets
        rd(8'h20, d, e);
        check("R9 data", d, 32'h0); check("R9 err", {31'h0, e}, 32'h1);
        rd(8'h11, d, e);
        check("R9 misaligned", {31'h0, e}, 32'h1);
        rd(8'h10, d, e);
        check("R9 mapped ok", {31'h0, e}, 32'h0);

        // R1 reset mid-run
        wr(8'h1C, 32'h1);
        wr(8'h00, 32'd302);
        wr(8'h10, 32'd300);
        ticks(2);
        check("R1 pre irq", {28'h0, irq}, 32'h1);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R1 irq clr", {28'h0, irq}, 32'h0);
        rd(8'h00, d, e); check("R1 cmp0", d, 32'h0);
        rd(8'h1C, d, e); check("R1 enable", d, 32'h0);
        rd(8'h18, d, e); check("R1 arm", d, 32'h0);
        rd(8'h10, d, e); check("R1 count re", d, 32'h0);

        done = 1'b1;
        summary();
    end
endmodule